// File: doc/BRIEF.md
# Addressed Serial Command Slave

This block is the slave end of a framed serial link between a host controller and a bank of control and status registers. The host pulls the active-low select line low, clocks in an address/command byte, and then either clocks in one or two write data bytes or clocks out one reply byte. The select, clock and data inputs are sampled by the block's system clock through synchronisers. Edges of the serial clock are found from the sampled copy, so the serial clock must be much slower than the system clock.

A completed write becomes a one-cycle strobe carrying the register address and up to sixteen data bits toward the register file. A completed reset command becomes a one-cycle reset strobe. A read presents the command byte as a read address, captures the status byte once, and shifts it out most significant bit first. Nothing is applied until the select line rises after all bytes of the command. A transaction cut short by an early rise of the select line leaves no trace. A completed read of the interrupt flag register also raises a read-clear strobe so the flags can be cleared after they have been seen.

Top module: `ser_cmd_slave`

## Requirements
- R1: Every byte, on input and on reply, travels most significant bit first. An input bit is taken on each rising edge of the serial clock while select is low.
- R2: Commands 0x80, 0x82, 0x88, 0x8B and 0x8E take one data byte. On completion `wr_stb_o` pulses for one cycle with `wr_addr_o` equal to the command, `wr_data_o[7:0]` equal to the byte, and `wr_data_o[15:8]` equal to zero.
- R3: Commands 0x83, 0x84 and 0x8A take two data bytes. The first byte sent lands in `wr_data_o[15:8]` and the second in `wr_data_o[7:0]`.
- R4: Command 0x01 takes no data. On completion it pulses `rst_all_o` for one cycle and raises no write strobe.
- R5: No strobe appears while select is still low, even after all bytes of a command have arrived. The strobe appears only after select rises.
- R6: A rise of select before the command's last bit aborts the transaction, and no strobe of any kind follows.
- R7: Commands 0x81 and 0x8F are reads. Once the command byte is in, `rd_addr_o` holds the command and `rd_data_i` is captured once. Its MSB is driven on `sdo_o` before the first reply clock edge, and each later rising edge advances one bit.
- R8: `sdo_oe_o` is high only while a reply byte is being sent. It is low while select is high, during command and write data bits, and after the eighth reply bit.
- R9: A completed read of 0x8F pulses `rd_clr_o` for one cycle after select rises. A read of 0x81, or a 0x8F read aborted before its eighth reply bit, gives no such pulse.
- R10: Any other command byte is ignored: no strobe of any kind follows, and `sdo_oe_o` stays low.
- R11: Extra serial clock edges after a command's last byte are ignored. The strobe then carries the data of the proper bytes.
- R12: After reset all strobes and `sdo_oe_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Active-low select framing a transaction |
| sdi_i | input | 1 | Serial command and write data from the host |
| sdo_o | output | 1 | Serial reply data |
| sdo_oe_o | output | 1 | Drive enable for the reply pad; the pad floats when low |
| wr_stb_o | output | 1 | One-cycle write strobe to the register file |
| wr_addr_o | output | 8 | Register address qualified by `wr_stb_o` |
| wr_data_o | output | 16 | Write data qualified by `wr_stb_o` |
| rst_all_o | output | 1 | One-cycle strobe resetting every register |
| rd_addr_o | output | 8 | Command byte of the current read |
| rd_data_i | input | 8 | Status byte for `rd_addr_o` |
| rd_clr_o | output | 1 | One-cycle read-clear strobe after a full flag register read |

## Verification
The assertions assume the serial clock's high and low phases each last several system clock cycles. They also assume the select and data lines change only while the serial clock is low, so each sampled rising edge sees settled data. The bench holds every serial clock phase for ten system cycles and changes data and select only in the low phase, well clear of the synchroniser delay. It also supplies the status byte as a steady function of `rd_addr_o`.

// File: rtl/ser_cmd_pkg.sv
package ser_cmd_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_DATA,
        S_RLOAD,
        S_REPLY,
        S_HOLD
    } frame_state_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_RESET,
        K_WR1,
        K_WR2,
        K_RD
    } cmd_kind_e;

    localparam logic [BYTE_W-1:0] CMD_RESET_ALL = 8'h01;
    localparam logic [BYTE_W-1:0] CMD_FLAG_READ = 8'h8F;

endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic csn_i,
    input  logic sdi_i,
    output logic sck_rise_o,
    output logic csn_s_o,
    output logic sdi_s_o
);
    // bit order within each stage: {sdi, csn, sck}
    localparam logic [2:0] IDLE_LVL = 3'b010;

    typedef struct packed {
        logic [STAGES-1:0][2:0] chain;
        logic                   sck_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d = q;
        d.chain[0] = {sdi_i, csn_i, sck_i};
        for (int i = 1; i < STAGES; i++) begin
            d.chain[i] = q.chain[i-1];
        end
        d.sck_prev = q.chain[STAGES-1][0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.chain    <= {STAGES{IDLE_LVL}};
            q.sck_prev <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sck_rise_o = q.chain[STAGES-1][0] & ~q.sck_prev;
    assign csn_s_o    = q.chain[STAGES-1][1];
    assign sdi_s_o    = q.chain[STAGES-1][2];

endmodule

// File: rtl/ser_cmd_decode.sv
module ser_cmd_decode
    import ser_cmd_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd_i,
    output cmd_kind_e         kind_o,
    output logic              clr_on_read_o
);
    always_comb begin
        kind_o        = K_NONE;
        clr_on_read_o = 1'b0;
        unique case (cmd_i)
            CMD_RESET_ALL:                      kind_o = K_RESET;
            8'h80, 8'h82, 8'h88, 8'h8B, 8'h8E:  kind_o = K_WR1;
            8'h83, 8'h84, 8'h8A:                kind_o = K_WR2;
            8'h81:                              kind_o = K_RD;
            CMD_FLAG_READ: begin
                kind_o        = K_RD;
                clr_on_read_o = 1'b1;
            end
            default:                            kind_o = K_NONE;
        endcase
    end
endmodule

// File: rtl/ser_frame.sv
module ser_frame
    import ser_cmd_pkg::*;
#(
    parameter int MAX_BYTES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sck_rise_i,
    input  logic                        csn_s_i,
    input  logic                        sdi_s_i,
    output logic [BYTE_W-1:0]           cmd_peek_o,
    input  cmd_kind_e                   kind_i,
    input  logic                        clr_on_read_i,
    output logic                        sdo_o,
    output logic                        sdo_oe_o,
    output logic                        wr_stb_o,
    output logic [BYTE_W-1:0]           wr_addr_o,
    output logic [BYTE_W*MAX_BYTES-1:0] wr_data_o,
    output logic                        rst_all_o,
    output logic [BYTE_W-1:0]           rd_addr_o,
    input  logic [BYTE_W-1:0]           rd_data_i,
    output logic                        rd_clr_o
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam int BUF_W = BYTE_W * MAX_BYTES;
    localparam int BC_W  = $clog2(MAX_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        frame_state_e      state;
        logic [CNT_W-1:0]  bit_cnt;
        logic [BC_W-1:0]   bytes_left;
        cmd_kind_e         kind;
        logic              clr_req;
        logic [BYTE_W-1:0] cmd;
        logic [BUF_W-1:0]  sh_in;
        logic [BYTE_W-1:0] sh_out;
        logic              oe;
        logic              wr_stb;
        logic [BYTE_W-1:0] wr_addr;
        logic [BUF_W-1:0]  wr_data;
        logic              rst_all;
        logic              rd_clr;
    } frame_t;

    frame_t q, d;

    assign cmd_peek_o = {q.sh_in[BYTE_W-2:0], sdi_s_i};

    always_comb begin
        d         = q;
        d.wr_stb  = 1'b0;
        d.rst_all = 1'b0;
        d.rd_clr  = 1'b0;
        if (csn_s_i) begin
            // deselected: a finished command is applied, anything else dropped
            if (q.state == S_HOLD) begin
                unique case (q.kind)
                    K_WR1: begin
                        d.wr_stb  = 1'b1;
                        d.wr_addr = q.cmd;
                        d.wr_data = BUF_W'(q.sh_in[BYTE_W-1:0]);
                    end
                    K_WR2: begin
                        d.wr_stb  = 1'b1;
                        d.wr_addr = q.cmd;
                        d.wr_data = q.sh_in;
                    end
                    K_RESET: d.rst_all = 1'b1;
                    K_RD:    d.rd_clr  = q.clr_req;
                    default: ;
                endcase
            end
            d.state = S_IDLE;
            d.oe    = 1'b0;
        end else begin
            unique case (q.state)
                S_IDLE: begin
                    d.state   = S_CMD;
                    d.bit_cnt = '0;
                    d.sh_in   = '0;
                    d.kind    = K_NONE;
                    d.clr_req = 1'b0;
                end
                S_CMD: begin
                    if (sck_rise_i) begin
                        d.sh_in = {q.sh_in[BUF_W-2:0], sdi_s_i};
                        if (q.bit_cnt == LAST_BIT) begin
                            d.cmd     = cmd_peek_o;
                            d.kind    = kind_i;
                            d.clr_req = clr_on_read_i;
                            d.bit_cnt = '0;
                            d.sh_in   = '0;
                            unique case (kind_i)
                                K_WR1: begin
                                    d.state      = S_DATA;
                                    d.bytes_left = '0;
                                end
                                K_WR2: begin
                                    d.state      = S_DATA;
                                    d.bytes_left = BC_W'(MAX_BYTES - 1);
                                end
                                K_RD:    d.state = S_RLOAD;
                                default: d.state = S_HOLD;
                            endcase
                        end else begin
                            d.bit_cnt = q.bit_cnt + 1'b1;
                        end
                    end
                end
                S_DATA: begin
                    if (sck_rise_i) begin
                        d.sh_in = {q.sh_in[BUF_W-2:0], sdi_s_i};
                        if (q.bit_cnt == LAST_BIT) begin
                            d.bit_cnt = '0;
                            if (q.bytes_left == '0) begin
                                d.state = S_HOLD;
                            end else begin
                                d.bytes_left = q.bytes_left - 1'b1;
                            end
                        end else begin
                            d.bit_cnt = q.bit_cnt + 1'b1;
                        end
                    end
                end
                S_RLOAD: begin
                    d.sh_out  = rd_data_i;
                    d.oe      = 1'b1;
                    d.bit_cnt = '0;
                    d.state   = S_REPLY;
                end
                S_REPLY: begin
                    if (sck_rise_i) begin
                        d.sh_out = {q.sh_out[BYTE_W-2:0], 1'b0};
                        if (q.bit_cnt == LAST_BIT) begin
                            d.oe    = 1'b0;
                            d.state = S_HOLD;
                        end else begin
                            d.bit_cnt = q.bit_cnt + 1'b1;
                        end
                    end
                end
                default: ;  // S_HOLD: extra edges ignored
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sdo_o     = q.sh_out[BYTE_W-1];
    assign sdo_oe_o  = q.oe;
    assign wr_stb_o  = q.wr_stb;
    assign wr_addr_o = q.wr_addr;
    assign wr_data_o = q.wr_data;
    assign rst_all_o = q.rst_all;
    assign rd_addr_o = q.cmd;
    assign rd_clr_o  = q.rd_clr;

    assert_pulses_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.wr_stb, q.rst_all, q.rd_clr}));

    assert_oe_low_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s_i |=> !q.oe);

    assert_stb_after_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wr_stb || q.rst_all || q.rd_clr) |-> $past(csn_s_i));

    assert_stb_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_stb |=> !q.wr_stb);

    assert_reply_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oe && !sck_rise_i && !csn_s_i && q.state == S_REPLY) |=> $stable(q.sh_out));

endmodule

// File: rtl/ser_cmd_slave.sv
module ser_cmd_slave
    import ser_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MAX_BYTES   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sck_i,
    input  logic                        csn_i,
    input  logic                        sdi_i,
    output logic                        sdo_o,
    output logic                        sdo_oe_o,
    output logic                        wr_stb_o,
    output logic [BYTE_W-1:0]           wr_addr_o,
    output logic [BYTE_W*MAX_BYTES-1:0] wr_data_o,
    output logic                        rst_all_o,
    output logic [BYTE_W-1:0]           rd_addr_o,
    input  logic [BYTE_W-1:0]           rd_data_i,
    output logic                        rd_clr_o
);
    logic              sck_rise, csn_s, sdi_s;
    logic [BYTE_W-1:0] cmd_peek;
    cmd_kind_e         kind;
    logic              clr_on_read;

    ser_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_i      (sck_i),
        .csn_i      (csn_i),
        .sdi_i      (sdi_i),
        .sck_rise_o (sck_rise),
        .csn_s_o    (csn_s),
        .sdi_s_o    (sdi_s)
    );

    ser_cmd_decode u_decode (
        .cmd_i         (cmd_peek),
        .kind_o        (kind),
        .clr_on_read_o (clr_on_read)
    );

    ser_frame #(.MAX_BYTES(MAX_BYTES)) u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .sck_rise_i    (sck_rise),
        .csn_s_i       (csn_s),
        .sdi_s_i       (sdi_s),
        .cmd_peek_o    (cmd_peek),
        .kind_i        (kind),
        .clr_on_read_i (clr_on_read),
        .sdo_o         (sdo_o),
        .sdo_oe_o      (sdo_oe_o),
        .wr_stb_o      (wr_stb_o),
        .wr_addr_o     (wr_addr_o),
        .wr_data_o     (wr_data_o),
        .rst_all_o     (rst_all_o),
        .rd_addr_o     (rd_addr_o),
        .rd_data_i     (rd_data_i),
        .rd_clr_o      (rd_clr_o)
    );

endmodule

// File: tb/ser_cmd_slave_bench.sv
module ser_cmd_slave_bench;
    localparam int HP = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, csn = 1'b1, sdi = 1'b0;
    logic        sdo, sdo_oe, wr_stb, rst_all, rd_clr;
    logic [7:0]  wr_addr, rd_addr, rd_data;
    logic [15:0] wr_data;

    int n_chk = 0, n_bad = 0;
    int cnt_wr = 0, cnt_rst = 0, cnt_clr = 0, cnt_oe_bad = 0;
    logic [7:0]  last_addr;
    logic [15:0] last_data;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // bench model of the status registers
    assign rd_data = (rd_addr == 8'h81) ? 8'hA5 : (rd_addr == 8'h8F) ? 8'h4C : 8'h00;

    ser_cmd_slave u_ser_cmd_slave (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr),
        .wr_data_o(wr_data), .rst_all_o(rst_all), .rd_addr_o(rd_addr),
        .rd_data_i(rd_data), .rd_clr_o(rd_clr)
    );

    always @(negedge clk) begin
        if (wr_stb) begin
            cnt_wr    <= cnt_wr + 1;
            last_addr <= wr_addr;
            last_data <= wr_data;
        end
        if (rst_all) cnt_rst <= cnt_rst + 1;
        if (rd_clr)  cnt_clr <= cnt_clr + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_counts();
        @(negedge clk);
        cnt_wr = 0; cnt_rst = 0; cnt_clr = 0; cnt_oe_bad = 0;
        last_addr = 8'h00; last_data = 16'h0000;
    endtask

    task automatic cs_begin();
        csn = 1'b0;
        wait_clk(HP);
    endtask

    task automatic cs_end();
        wait_clk(HP);
        csn = 1'b1;
        wait_clk(HP);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sdi = b[i];
            wait_clk(HP);
            @(negedge clk);
            if (sdo_oe) cnt_oe_bad++;
            wait_clk(1);
            sck = 1'b1;
            wait_clk(HP);
            sck = 1'b0;
        end
    endtask

    task automatic read_byte(input int nbits, output logic [7:0] b);
        b = 8'h00;
        for (int i = 7; i >= 8 - nbits; i--) begin
            wait_clk(HP);
            @(negedge clk);
            if (!sdo_oe) cnt_oe_bad++;
            b[i] = sdo;
            wait_clk(1);
            sck = 1'b1;
            wait_clk(HP);
            sck = 1'b0;
        end
    endtask

    task automatic t_reset_state();
        check("R12 oe", {31'b0, sdo_oe}, 0);
        check("R12 strobes", {29'b0, wr_stb, rst_all, rd_clr}, 0);
    endtask

    task automatic t_write1(input logic [7:0] cmd, input logic [7:0] val);
        clear_counts();
        cs_begin(); send_byte(cmd); send_byte(val);
        wait_clk(HP);
        check("R5 no strobe before select rise", cnt_wr, 0);
        cs_end();
        check("R2 one write", cnt_wr, 1);
        check("R2 addr", {24'b0, last_addr}, {24'b0, cmd});
        check("R1 R2 data", {16'b0, last_data}, {24'b0, val});
        check("R8 oe low during write", cnt_oe_bad, 0);
    endtask

    task automatic t_write2(input logic [7:0] cmd, input logic [15:0] val);
        clear_counts();
        cs_begin(); send_byte(cmd); send_byte(val[15:8]); send_byte(val[7:0]);
        cs_end();
        check("R3 one write", cnt_wr, 1);
        check("R3 addr", {24'b0, last_addr}, {24'b0, cmd});
        check("R3 data order", {16'b0, last_data}, {16'b0, val});
    endtask

    task automatic t_reset_cmd();
        clear_counts();
        cs_begin(); send_byte(8'h01); cs_end();
        check("R4 reset strobe", cnt_rst, 1);
        check("R4 no write", cnt_wr, 0);
    endtask

    task automatic t_abort_write();
        clear_counts();
        cs_begin(); send_byte(8'h83); send_byte(8'h12);
        cs_end();
        check("R6 aborted two-byte write", cnt_wr + cnt_rst + cnt_clr, 0);
        clear_counts();
        cs_begin(); send_byte(8'h80);
        for (int i = 7; i >= 4; i--) begin
            sdi = 1'b1; wait_clk(HP); sck = 1'b1; wait_clk(HP); sck = 1'b0;
        end
        cs_end();
        check("R6 aborted mid-byte", cnt_wr, 0);
        t_write1(8'h88, 8'h3C);  // next frame starts clean after an abort
    endtask

    task automatic t_read(input logic [7:0] cmd, input logic [7:0] exp, input int clr_exp);
        logic [7:0] got;
        clear_counts();
        cs_begin(); send_byte(cmd);
        check("R7 read address", {24'b0, rd_addr}, {24'b0, cmd});
        read_byte(8, got);
        check("R1 R7 reply byte", {24'b0, got}, {24'b0, exp});
        check("R8 oe high during reply", cnt_oe_bad, 0);
        wait_clk(HP);
        check("R8 oe low after reply", {31'b0, sdo_oe}, 0);
        cs_end();
        check("R9 read-clear count", cnt_clr, clr_exp);
        check("R9 no write on read", cnt_wr, 0);
    endtask

    task automatic t_abort_read();
        logic [7:0] got;
        clear_counts();
        cs_begin(); send_byte(8'h8F); read_byte(5, got);
        check("R7 partial reply", {24'b0, got[7:3]}, {27'b0, 5'b01001});
        cs_end();
        check("R9 aborted flag read", cnt_clr, 0);
        check("R8 oe low after deselect", {31'b0, sdo_oe}, 0);
    endtask

    task automatic t_unknown();
        clear_counts();
        cs_begin(); send_byte(8'h42); send_byte(8'hFF);
        check("R10 oe low", cnt_oe_bad, 0);
        cs_end();
        check("R10 ignored", cnt_wr + cnt_rst + cnt_clr, 0);
    endtask

    task automatic t_extra_edges();
        clear_counts();
        cs_begin(); send_byte(8'h8E); send_byte(8'h44); send_byte(8'hFF);
        cs_end();
        check("R11 one write", cnt_wr, 1);
        check("R11 data kept", {16'b0, last_data}, 32'h44);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        wait_clk(5);
        t_reset_state();
        rst_n = 1'b1;
        wait_clk(5);
        t_reset_state();
        t_write1(8'h80, 8'hC3);
        t_write1(8'h8B, 8'h5A);
        t_write2(8'h84, 16'h5CB1);
        t_write2(8'h8A, 16'h2F3E);
        t_reset_cmd();
        t_abort_write();
        t_read(8'h81, 8'hA5, 0);
        t_read(8'h8F, 8'h4C, 1);
        t_abort_read();
        t_unknown();
        t_extra_edges();
        finish_run();
    end
endmodule